// File: doc/BRIEF.md
# Store Write Buffer with Load Forwarding

This block sits between a processor's store port and a slower memory write port. Each store (word address, data and an age tag) is taken in a single cycle and held in a small circular queue. The queue then empties itself toward memory in arrival order through a valid/ready handshake, independently of whatever the store port is doing. When every slot is taken, the store port sees its ready signal drop until a slot frees.

Loads search the queue before going to memory. If one or more held stores match the load address, the data of the youngest matching store comes back one cycle later with a hit flag. Otherwise a miss flag tells the surrounding logic to issue the memory read. Fence and atomic requests are held off, each with its own ready signal, until the queue is completely empty. On an exception, a squash input with a tag throws away every held store whose tag is at or above that tag, so none of them ever reaches memory.

Top module: `store_wbuf`

## Requirements
- R1: After synchronous reset the queue is empty: `mem_valid` is 0, `st_ready` is 1 and a raised `fence_req` sees `fence_ready` at 1.
- R2: A store is taken on every clock edge where `st_valid` and `st_ready` are both 1, and `st_ready` is 1 whenever fewer than DEPTH stores are held and no squash is presented.
- R3: Held stores leave on `mem_addr`/`mem_data` in the order they were taken. The head store leaves only on an edge where `mem_valid` and `mem_ready` are both 1, and it stays unchanged on the memory port while `mem_ready` is 0.
- R4: With DEPTH stores held and `mem_ready` at 0, `st_ready` is 0, and a store presented then is not taken.
- R5: With DEPTH stores held, `mem_ready` at 1 and no squash, `st_ready` is 1, and the store taken in that cycle becomes the youngest entry.
- R6: A load (`ld_valid` at 1) whose address matches one or more held stores gives, on the next cycle, `ld_hit`=1, `ld_miss`=0 and `ld_data` equal to the data of the youngest matching store.
- R7: A load that matches no held store gives, on the next cycle, `ld_miss`=1, `ld_hit`=0 and `ld_data`=0. In cycles after no load, both flags are 0.
- R8: A store taken in the same cycle as a load to the same address counts as the youngest match for that load.
- R9: `fence_ready` is 1 only while `fence_req` is 1 and the queue is empty, so it stays 0 until every held store has been accepted by memory.
- R10: `atomic_ready` follows the same rule as `fence_ready`, gated by `atomic_req`.
- R11: On an edge with `squash_valid` at 1, every held store whose tag is, as an unsigned number, greater than or equal to `squash_tag` is removed and never appears on the memory port. Tags increase from older to younger stores. `st_ready` is 0 while `squash_valid` is 1. A head store that memory accepts on that same edge still counts as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_tag | input | TAG_W | Store age tag |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load word address |
| ld_hit | output | 1 | Previous-cycle load found in the queue |
| ld_miss | output | 1 | Previous-cycle load must go to memory |
| ld_data | output | DATA_W | Forwarded data on a hit, 0 otherwise |
| fence_req | input | 1 | Fence waiting for an empty queue |
| fence_ready | output | 1 | Fence may proceed |
| atomic_req | input | 1 | Atomic operation waiting for an empty queue |
| atomic_ready | output | 1 | Atomic may proceed |
| squash_valid | input | 1 | Exception squash |
| squash_tag | input | TAG_W | Oldest tag to discard |
| mem_valid | output | 1 | Head store offered to memory |
| mem_ready | input | 1 | Memory accepts the head store |
| mem_addr | output | ADDR_W | Head store address |
| mem_data | output | DATA_W | Head store data |

## Verification
The bench builds the buffer with DEPTH 4, 8-bit addresses, 16-bit data and 4-bit tags. With this depth, the full condition and the same-cycle enqueue with drain are reached after four stores. Repeated addresses among a handful of entries show that the youngest match is picked, and a few tags are enough to squash part of the queue and then all of it.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // Registered outcome of a load lookup
  typedef enum logic [1:0] {
    LR_NONE = 2'd0,
    LR_HIT  = 2'd1,
    LR_MISS = 2'd2
  } ld_resp_e;
endpackage

// File: rtl/wbuf_entries.sv
// Entry arrays: written at the tail, no reset, read in parallel.
module wbuf_entries #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  output logic [ADDR_W-1:0] addr_q [DEPTH],
  output logic [DATA_W-1:0] data_q [DEPTH],
  output logic [TAG_W-1:0]  tag_q  [DEPTH]
);
  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_q[wr_ptr] <= wr_addr;
      data_q[wr_ptr] <= wr_data;
      tag_q[wr_ptr]  <= wr_tag;
    end
  end
endmodule

// File: rtl/wbuf_ctrl.sv
// Head pointer and occupancy, including squash rollback of the tail.
module wbuf_ctrl #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             squash,
  input  logic [TAG_W-1:0] sq_tag,
  input  logic [TAG_W-1:0] tag_q [DEPTH],
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] occ
);
  logic [CNT_W-1:0] keep;
  logic [CNT_W-1:0] occ_nxt;
  logic [PTR_W-1:0] idx;

  // Survivors form a prefix from the head because tags rise toward the tail.
  always_comb begin
    keep = '0;
    idx  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (CNT_W'(k) < occ && tag_q[idx] < sq_tag)
        keep = keep + 1'b1;
    end
    if (squash)
      occ_nxt = (pop && keep != '0) ? keep - 1'b1 : keep;
    else
      occ_nxt = occ + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      occ  <= '0;
    end else begin
      head <= head + PTR_W'(pop);
      occ  <= occ_nxt;
    end
  end

  assign tail = head + occ[PTR_W-1:0];
endmodule

// File: rtl/wbuf_lookup.sv
// Associative search of held stores; the youngest match wins.
module wbuf_lookup #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] addr_q [DEPTH],
  input  logic [DATA_W-1:0] data_q [DEPTH],
  input  logic [PTR_W-1:0]  head,
  input  logic [CNT_W-1:0]  occ,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              byp_en,
  input  logic [ADDR_W-1:0] byp_addr,
  input  logic [DATA_W-1:0] byp_data,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data
);
  logic [PTR_W-1:0] idx;

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = '0;
    // Walk oldest to youngest so a later match overrides an earlier one.
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (CNT_W'(k) < occ && addr_q[idx] == ld_addr) begin
        hit      = 1'b1;
        hit_data = data_q[idx];
      end
    end
    // A store entering this cycle is younger than every held entry.
    if (byp_en && byp_addr == ld_addr) begin
      hit      = 1'b1;
      hit_data = byp_data;
    end
  end
endmodule

// File: rtl/store_wbuf.sv
module store_wbuf
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic              ld_miss,
  output logic [DATA_W-1:0] ld_data,
  input  logic              fence_req,
  output logic              fence_ready,
  input  logic              atomic_req,
  output logic              atomic_ready,
  input  logic              squash_valid,
  input  logic [TAG_W-1:0]  squash_tag,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  occ;
  logic              push, pop, empty, full;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;
  ld_resp_e          ld_q;
  logic [DATA_W-1:0] ld_data_q;

  assign empty     = (occ == '0);
  assign full      = (occ == CNT_W'(DEPTH));
  assign mem_valid = !empty;
  assign pop       = mem_valid && mem_ready;
  // A full queue still takes a store when the head leaves on the same edge.
  assign st_ready  = !squash_valid && (!full || mem_ready);
  assign push      = st_valid && st_ready;

  wbuf_entries #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_entries (
    .clk(clk), .wr_en(push), .wr_ptr(tail),
    .wr_addr(st_addr), .wr_data(st_data), .wr_tag(st_tag),
    .addr_q(addr_q), .data_q(data_q), .tag_q(tag_q)
  );

  wbuf_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .squash(squash_valid), .sq_tag(squash_tag), .tag_q(tag_q),
    .head(head), .tail(tail), .occ(occ)
  );

  wbuf_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lookup (
    .addr_q(addr_q), .data_q(data_q), .head(head), .occ(occ),
    .ld_addr(ld_addr), .byp_en(push), .byp_addr(st_addr), .byp_data(st_data),
    .hit(lk_hit), .hit_data(lk_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q      <= LR_NONE;
      ld_data_q <= '0;
    end else begin
      ld_q      <= !ld_valid ? LR_NONE : (lk_hit ? LR_HIT : LR_MISS);
      ld_data_q <= (ld_valid && lk_hit) ? lk_data : '0;
    end
  end

  assign ld_hit       = (ld_q == LR_HIT);
  assign ld_miss      = (ld_q == LR_MISS);
  assign ld_data      = ld_data_q;
  assign mem_addr     = addr_q[head];
  assign mem_data     = data_q[head];
  assign fence_ready  = fence_req && empty;
  assign atomic_ready = atomic_req && empty;
endmodule

// File: rtl/store_wbuf_chk.sv
module store_wbuf_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              st_ready,
  input logic              ld_valid,
  input logic              ld_hit,
  input logic              ld_miss,
  input logic              fence_ready,
  input logic              atomic_ready,
  input logic              squash_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [CNT_W-1:0]  occ
);
  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));
  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready && !squash_valid) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CNT_W'(DEPTH) && !mem_ready) |-> !st_ready);
  // R5
  full_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CNT_W'(DEPTH) && mem_ready && !squash_valid) |-> st_ready);
  // R7
  ld_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld_hit && ld_miss));
  // R6
  ld_answer_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (ld_hit || ld_miss));
  // R7
  ld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> (!ld_hit && !ld_miss));
  // R9
  fence_empty_chk: assert property (@(posedge clk) disable iff (rst)
    fence_ready |-> !mem_valid);
  // R10
  atomic_empty_chk: assert property (@(posedge clk) disable iff (rst)
    atomic_ready |-> !mem_valid);
  // R11
  squash_block_chk: assert property (@(posedge clk) disable iff (rst)
    squash_valid |-> !st_ready);
endmodule

bind store_wbuf store_wbuf_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .st_ready(st_ready), .ld_valid(ld_valid),
  .ld_hit(ld_hit), .ld_miss(ld_miss), .fence_ready(fence_ready),
  .atomic_ready(atomic_ready), .squash_valid(squash_valid),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .occ(occ)
);

// File: tb/store_wbuf_test.sv
module store_wbuf_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_valid = 1'b0, ld_valid = 1'b0, fence_req = 1'b0, atomic_req = 1'b0;
  logic squash_valid = 1'b0, mem_ready = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [TW-1:0] st_tag = '0, squash_tag = '0;
  logic st_ready, ld_hit, ld_miss, fence_ready, atomic_ready, mem_valid;
  logic [DW-1:0] ld_data, mem_data;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int ln = 0;
  logic [AW-1:0] la [32];
  logic [DW-1:0] lda [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  store_wbuf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) uut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_tag(st_tag),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit),
    .ld_miss(ld_miss), .ld_data(ld_data), .fence_req(fence_req),
    .fence_ready(fence_ready), .atomic_req(atomic_req),
    .atomic_ready(atomic_ready), .squash_valid(squash_valid),
    .squash_tag(squash_tag), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // Memory model: records every accepted write in order
  always @(posedge clk) begin
    if (!rst && mem_valid && mem_ready && ln < 32) begin
      la[ln]  = mem_addr;
      lda[ln] = mem_data;
      ln      = ln + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [TW-1:0] t);
    st_valid = 1'b1; st_addr = a; st_data = d; st_tag = t;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a);
    ld_valid = 1'b1; ld_addr = a;
    tick();
    ld_valid = 1'b0;
  endtask

  task automatic drain();
    mem_ready = 1'b1;
    for (int i = 0; i < 40 && mem_valid; i++) tick();
    mem_ready = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 st_ready", st_ready, 1);
    fence_req = 1'b1; #1;
    chk("R1 fence_ready", fence_ready, 1);
    fence_req = 1'b0;
  endtask

  task automatic t_order();
    ln = 0;
    push(8'h11, 16'hA001, 1);
    push(8'h22, 16'hA002, 2);
    push(8'h33, 16'hA003, 3);
    chk("R2 st_ready partly full", st_ready, 1);
    tick(); tick();
    chk("R3 hold addr", mem_addr, 8'h11);
    chk("R3 no write without ready", ln, 0);
    drain();
    chk("R3 count", ln, 3);
    chk("R3 first addr", la[0], 8'h11);
    chk("R3 second addr", la[1], 8'h22);
    chk("R3 third data", lda[2], 16'hA003);
  endtask

  task automatic t_full();
    ln = 0;
    for (int i = 1; i <= DEPTH; i++) push(AW'(i), DW'(16'hB000 + i), TW'(i));
    chk("R4 full stall", st_ready, 0);
    st_valid = 1'b1; st_addr = 8'h66; st_data = 16'hBEEF; st_tag = 4'd9;
    tick();
    chk("R4 rejected store leaves nothing", ln, 0);
    st_addr = 8'h05; st_data = 16'hB005; st_tag = 4'd5;
    mem_ready = 1'b1; #1;
    chk("R5 full with drain ready", st_ready, 1);
    tick();
    st_valid = 1'b0;
    drain();
    chk("R5 count", ln, 5);
    chk("R4 oldest first", la[0], 8'h01);
    chk("R5 new store last", la[4], 8'h05);
    chk("R5 new store data", lda[4], 16'hB005);
  endtask

  task automatic t_forward();
    ln = 0;
    push(8'h10, 16'hC001, 1);
    push(8'h20, 16'hC002, 2);
    push(8'h10, 16'hC003, 3);
    load(8'h10);
    chk("R6 hit", ld_hit, 1);
    chk("R6 no miss", ld_miss, 0);
    chk("R6 youngest data", ld_data, 16'hC003);
    load(8'h20);
    chk("R6 single match data", ld_data, 16'hC002);
    load(8'h30);
    chk("R7 miss", ld_miss, 1);
    chk("R7 no hit", ld_hit, 0);
    chk("R7 zero data", ld_data, 0);
    tick();
    chk("R7 idle flags", {ld_hit, ld_miss}, 0);
    drain();
    load(8'h10);
    chk("R7 miss after drain", ld_miss, 1);
  endtask

  task automatic t_bypass();
    ln = 0;
    push(8'h44, 16'hD001, 1);
    st_valid = 1'b1; st_addr = 8'h44; st_data = 16'hD002; st_tag = 2;
    ld_valid = 1'b1; ld_addr = 8'h44;
    tick();
    st_valid = 1'b0; ld_valid = 1'b0;
    chk("R8 same-cycle hit", ld_hit, 1);
    chk("R8 same-cycle data", ld_data, 16'hD002);
    drain();
  endtask

  task automatic t_fence();
    ln = 0;
    push(8'h51, 16'hE001, 1);
    push(8'h52, 16'hE002, 2);
    fence_req = 1'b1; atomic_req = 1'b1; #1;
    chk("R9 fence waits", fence_ready, 0);
    chk("R10 atomic waits", atomic_ready, 0);
    mem_ready = 1'b1;
    tick();
    chk("R9 fence waits one left", fence_ready, 0);
    chk("R10 atomic waits one left", atomic_ready, 0);
    tick();
    mem_ready = 1'b0;
    chk("R9 fence after drain", fence_ready, 1);
    chk("R10 atomic after drain", atomic_ready, 1);
    chk("R9 drained count", ln, 2);
    fence_req = 1'b0; atomic_req = 1'b0;
  endtask

  task automatic t_squash();
    ln = 0;
    push(8'h60, 16'hF001, 1);
    push(8'h61, 16'hF002, 2);
    push(8'h62, 16'hF003, 3);
    push(8'h63, 16'hF004, 4);
    squash_valid = 1'b1; squash_tag = 4'd3; #1;
    chk("R11 store blocked in squash", st_ready, 0);
    tick();
    squash_valid = 1'b0;
    load(8'h62);
    chk("R11 squashed entry misses", ld_miss, 1);
    load(8'h61);
    chk("R11 older entry kept", ld_data, 16'hF002);
    drain();
    chk("R11 survivors written", ln, 2);
    chk("R11 last survivor", la[1], 8'h61);
    ln = 0;
    push(8'h70, 16'h0701, 5);
    push(8'h71, 16'h0702, 6);
    squash_valid = 1'b1; squash_tag = 4'd0;
    tick();
    squash_valid = 1'b0;
    chk("R11 squash all empties", mem_valid, 0);
    mem_ready = 1'b1; tick(); tick(); mem_ready = 1'b0;
    chk("R11 nothing written", ln, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_order();
    t_full();
    t_forward();
    t_bypass();
    t_fence();
    t_squash();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule